// File: doc/BRIEF.md
# Auxiliary ADC Register Front-End

This block is the software-facing control layer of a 16-channel auxiliary analog-to-digital converter. Software talks to it over a plain 32-bit register bus: address, write strobe, write data, read strobe and read data. A conversion of channel n is requested by moving bit n of a shared trigger register from 0 to 1. The block records that request, and when the converter is free it selects the channel and issues a one-cycle start pulse. When the converter reports done, the block stores the 12-bit result in that channel's data register and sets the channel's ready flag.

Requests that arrive together, or while a conversion is running, wait in a pending set. They are granted one at a time, lowest channel first. A single status bit shows whether a conversion is in flight. A power-enable bit in a miscellaneous register must be set before any conversion can start. Clearing it drops all outstanding work, and the stored results stay in place.

Writing 0 to a channel's trigger bit clears that channel's ready flag. This lets software confirm that the stale flag has gone before it asks again. Reads are combinational and are qualified by the read strobe.

Top module: `auxadc_regs`

## Requirements
- R1: The 32-bit register at offset 0x00 is plain storage. A write stores all 32 bits, and a read returns them unchanged.
- R2: The trigger register is at offset 0x04, bits 15:0, with bit n belonging to channel n. A write that changes bit n from 0 to 1 while power is enabled queues exactly one conversion of channel n. A rise that happens while power is disabled is dropped.
- R3: Bit 0 of the status register at offset 0x10 reads 1 from the cycle the start pulse is issued up to and including the cycle in which done is seen. It reads 0 from the next cycle on.
- R4: The data register of channel n is at offset 0x14 + 4*n. Bits 11:0 hold the last result and bit 12 is the ready flag. The result and the flag are both captured in the cycle in which done is seen while a conversion is in flight. A done pulse outside a conversion changes nothing.
- R5: Writing 0 to bit n of the trigger register clears channel n's ready flag and leaves its stored result unchanged.
- R6: The start output is a one-cycle pulse, issued together with the selected channel on the channel-select output. Pending requests are served one at a time in ascending channel order, each exactly once. No new start is issued before status has returned to 0.
- R7: Power enable is bit 14 of the register at offset 0x94. While it is 0, no conversion starts. Clearing it abandons every pending request and the conversion in flight, so status reads 0 from the cycle after the write takes effect. Stored results and ready flags are kept.
- R8: Unused bits and unmapped or unaligned addresses read as 0. Writes to the status register or to a data register have no effect. A read with the read strobe low returns 0.
- R9: No start is issued in the cycle after the converter's busy input was high. A request waits until that input is low.
- R10: Reset clears the storage register, the trigger bits, power enable, all pending requests, all results and all ready flags, and leaves status at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, 0 when bus_rd is low |
| conv_sel | output | 4 | Channel presented to the converter |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_busy | input | 1 | Converter not ready to accept a start |
| conv_done | input | 1 | Converter result valid this cycle |
| conv_result | input | 12 | Converter result |

## Verification
The bench applies several trigger patterns and checks each against a behavioural model on every clock:
- A single isolated trigger shows the basic start-to-ready timing.
- A multi-bit write with bits far apart shows whether the grant order is ascending and whether each request is served only once.
- A trigger that arrives while a conversion is running shows that requests queue behind the active one.
- Holding the converter's busy input high separates the request path from the start gating.
- Dropping power in the middle of a queued batch shows that pending work is abandoned and that stored results are kept.
- Writes to read-only locations and reads of unmapped addresses show that those accesses leave no trace.

// File: rtl/auxadc_regs.sv
module auxadc_regs #(
  parameter int NCH = 16,
  parameter int RW  = 12,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic [$clog2(NCH)-1:0] conv_sel,
  output logic          conv_start,
  input  logic          conv_busy,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_result
);
  localparam int CW = $clog2(NCH);
  localparam int PWR_BIT = 14;
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_TRIG = AW'(8'h04);
  localparam logic [AW-1:0] A_STAT = AW'(8'h10);
  localparam logic [AW-1:0] A_DATA = AW'(8'h14);
  localparam logic [AW-1:0] A_MISC = AW'(8'h94);
  localparam logic [AW-1:0] A_DEND = AW'(8'h14 + 4 * NCH);

  logic [DW-1:0]  ctrl_q;
  logic [NCH-1:0] trig_q, pend_q, ready_q;
  logic           pwr_q, busy_q, start_q;
  logic [CW-1:0]  sel_q, pick;
  logic [RW-1:0]  data_q [NCH];

  wire wr_trig = bus_wr && bus_addr == A_TRIG;
  wire [NCH-1:0] rise = wr_trig ? (bus_wdata[NCH-1:0] & ~trig_q) : '0;
  wire [NCH-1:0] fall = wr_trig ? ~bus_wdata[NCH-1:0] : '0;
  wire grant    = !busy_q && pwr_q && (|pend_q) && !conv_busy;
  wire done_hit = busy_q && pwr_q && conv_done;
  wire [NCH-1:0] grant_mask = grant ? (NCH'(1) << pick) : '0;
  wire [NCH-1:0] done_mask  = done_hit ? (NCH'(1) << sel_q) : '0;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) pick = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      trig_q  <= '0;
      pend_q  <= '0;
      ready_q <= '0;
      pwr_q   <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      sel_q   <= '0;
      for (int i = 0; i < NCH; i++) data_q[i] <= '0;
    end else begin
      start_q <= grant;
      if (grant) sel_q <= pick;
      if (done_hit) data_q[sel_q] <= conv_result;
      ready_q <= (ready_q | done_mask) & ~fall;
      pend_q  <= pwr_q ? ((pend_q & ~grant_mask) | rise) : '0;
      if (!pwr_q)        busy_q <= 1'b0;
      else if (grant)    busy_q <= 1'b1;
      else if (done_hit) busy_q <= 1'b0;
      if (wr_trig) trig_q <= bus_wdata[NCH-1:0];
      if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata;
      if (bus_wr && bus_addr == A_MISC) pwr_q <= bus_wdata[PWR_BIT];
    end
  end

  wire in_data = bus_addr >= A_DATA && bus_addr < A_DEND && bus_addr[1:0] == 2'b00;
  wire [AW-1:0] doff = bus_addr - A_DATA;
  wire [CW-1:0] didx = CW'(doff >> 2);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_CTRL)      bus_rdata = ctrl_q;
      else if (bus_addr == A_TRIG) bus_rdata = DW'(trig_q);
      else if (bus_addr == A_STAT) bus_rdata = DW'(busy_q);
      else if (bus_addr == A_MISC) bus_rdata = DW'(pwr_q) << PWR_BIT;
      else if (in_data)            bus_rdata = DW'({ready_q[didx], data_q[didx]});
    end
  end

  assign conv_start = start_q;
  assign conv_sel   = sel_q;
endmodule

// File: rtl/auxadc_regs_chk.sv
module auxadc_regs_chk #(
  parameter int NCH = 16,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_start,
  input logic           conv_busy,
  input logic           conv_done,
  input logic           bus_wr,
  input logic [7:0]     bus_addr,
  input logic           busy_q,
  input logic           pwr_q,
  input logic [CW-1:0]  sel_q,
  input logic [NCH-1:0] ready_q
);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy_q);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pwr_q && conv_done) |=> !busy_q);

  // R4
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pwr_q && conv_done && !(bus_wr && bus_addr == 8'h04)) |=> ready_q[sel_q]);

  // R7
  power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> !busy_q && !conv_start);

  // R9
  conv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !conv_start);
endmodule

bind auxadc_regs auxadc_regs_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_busy(conv_busy),
  .conv_done(conv_done), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .busy_q(busy_q), .pwr_q(pwr_q), .sel_q(sel_q), .ready_q(ready_q)
);

// File: tb/sim_auxadc_regs.sv
module sim_auxadc_regs;
  localparam int CLK = 10;
  localparam int LAT = 5;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  conv_sel;
  logic        conv_start;
  logic        conv_busy = 0, conv_done = 0;
  logic [11:0] conv_result = 0;

  auxadc_regs u0 (.*);

  always #(CLK/2) clk = ~clk;

  int vectors = 0, fails = 0, nconv = 0, cnt = 0;
  bit finished = 0;
  string ph = "R10";

  logic [31:0] m_ctrl;
  logic [15:0] m_trig, m_pend, m_ready;
  logic [11:0] m_data [16];
  logic        m_pwr, m_busy, m_start;
  logic [3:0]  m_sel;

  function automatic logic [31:0] mread(logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h04) return {16'h0, m_trig};
    if (a == 8'h10) return {31'h0, m_busy};
    if (a == 8'h94) return {17'h0, m_pwr, 14'h0};
    if (a >= 8'h14 && a <= 8'h50 && a[1:0] == 0) begin
      int n = (int'(a) - 'h14) / 4;
      return {19'h0, m_ready[n], m_data[n]};
    end
    return 0;
  endfunction

  function automatic string tagof(logic [7:0] a);
    if (a == 8'h00) return "R1";
    if (a == 8'h04) return "R2";
    if (a == 8'h10) return "R3";
    if (a == 8'h94) return "R7";
    if (a >= 8'h14 && a <= 8'h50 && a[1:0] == 0) return "R4";
    return "R8";
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_trig = 0; m_pend = 0; m_ready = 0;
      m_pwr = 0; m_busy = 0; m_start = 0; m_sel = 0;
      for (int i = 0; i < 16; i++) m_data[i] = 0;
    end else begin
      logic o_busy, o_pwr, done, grant;
      logic [15:0] o_pend;
      int low;
      o_busy = m_busy; o_pwr = m_pwr; o_pend = m_pend;
      done = o_busy && o_pwr && conv_done;
      grant = !o_busy && o_pwr && o_pend != 0 && !conv_busy;
      low = 0;
      for (int i = 15; i >= 0; i--) if (o_pend[i]) low = i;
      m_start = grant;
      if (done) begin
        m_data[m_sel] = conv_result;
        m_ready[m_sel] = 1;
      end
      if (grant) begin
        m_sel = 4'(low);
        m_pend[low] = 0;
      end
      if (!o_pwr) m_busy = 0;
      else if (grant) m_busy = 1;
      else if (done) m_busy = 0;
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_ctrl = bus_wdata;
        if (bus_addr == 8'h94) m_pwr = bus_wdata[14];
        if (bus_addr == 8'h04) begin
          for (int i = 0; i < 16; i++) begin
            if (bus_wdata[i] && !m_trig[i] && o_pwr) m_pend[i] = 1;
            if (!bus_wdata[i]) m_ready[i] = 0;
          end
          m_trig = bus_wdata[15:0];
        end
      end
      if (!o_pwr) m_pend = 0;
    end
  end

  // comparison a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK/4);
    if (!finished) begin
      vectors++;
      if (conv_start !== m_start || (m_start && conv_sel !== m_sel)) begin
        fails++;
        $display("FAIL R6 [%s] start/sel actual %b/%0d expected %b/%0d",
                 ph, conv_start, conv_sel, m_start, m_sel);
      end
      if (bus_rd) begin
        vectors++;
        if (bus_rdata !== mread(bus_addr)) begin
          fails++;
          $display("FAIL %s [%s] addr %h actual %h expected %h",
                   tagof(bus_addr), ph, bus_addr, bus_rdata, mread(bus_addr));
        end
      end
    end
  end

  // converter stub with a fixed latency
  always @(negedge clk) begin
    conv_done = 0;
    if (conv_start) begin
      cnt = LAT;
      nconv++;
      conv_result = 12'((int'(conv_sel) * 37 + nconv * 91) ^ 12'hA5A);
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) conv_done = 1;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1; bus_wr = 0;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic poll(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_addr = 8'h10; bus_rd = 1; bus_wr = 0;
    end
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rd_all();
    for (int i = 0; i < 16; i++) rd(8'(8'h14 + 4 * i));
  endtask

  initial begin
    ph = "R10";
    repeat (3) @(negedge clk);
    // reads while still in reset, then after release
    rd(8'h00); rd(8'h10);
    rst_n = 1;
    rd(8'h00); rd(8'h04); rd(8'h10); rd(8'h94);
    rd_all();

    ph = "R1";
    wr(8'h00, 32'hDEADBEEF); rd(8'h00);
    wr(8'h00, 32'h0123F00D); rd(8'h00);

    ph = "R7";
    wr(8'h04, 32'h0000_0008);
    poll(12); rd(8'h20);
    wr(8'h04, 32'h0);
    wr(8'h94, 32'hFFFF_FFFF); rd(8'h94);

    ph = "R2";
    wr(8'h04, 32'hFFFF_0020); rd(8'h04);
    poll(12); rd(8'h28);

    ph = "R6";
    wr(8'h04, 32'h0000_8421);
    poll(30); rd_all();

    ph = "R5";
    wr(8'h04, 32'h0000_0400); rd_all();
    wr(8'h04, 32'h0); rd_all();

    ph = "R9";
    conv_busy = 1;
    wr(8'h04, 32'h0000_0004);
    poll(8);
    @(negedge clk); conv_busy = 0;
    poll(12); rd(8'h1C);

    ph = "R6";
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h0000_0080);
    poll(2);
    wr(8'h04, 32'h0000_0082);
    wr(8'h04, 32'h0000_1082);
    poll(30); rd_all();

    ph = "R7";
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h0000_1A00);
    poll(3);
    wr(8'h94, 32'h0);
    poll(15); rd_all();
    wr(8'h94, 32'h0000_4000);
    poll(15); rd_all();

    ph = "R8";
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14);
    wr(8'h50, 32'h0000_1FFF); rd(8'h50);
    rd(8'h08); rd(8'h0C); rd(8'h15); rd(8'h54); rd(8'h98); rd(8'hFC);
    @(negedge clk); bus_addr = 8'h00; bus_rd = 0;
    @(negedge clk);
    vectors++;
    if (bus_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R8 idle read actual %h expected %h", bus_rdata, 32'h0);
    end

    ph = "R4";
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h0000_0001);
    poll(12); rd(8'h14);

    ph = "R10";
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(8'h00); rd(8'h04); rd(8'h94); rd(8'h10);
    rd_all();

    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK * 100000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule